// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of an Ethernet management serial link. It produces the management clock (MDC) and drives or releases the bidirectional data line (MDIO) so that software can reach registers inside one or more PHYs. Software works through one 32-bit command register. A single write with the go bit set launches exactly one management frame. The frame is either a Clause 22 frame or a Clause 45 frame, chosen by the start-code field of that write.

A Clause 45 access takes two commands issued one after the other. The first is an address frame: its 5-bit register field names the device (MMD) and its 16-bit field holds the register address. The second is a write or read frame to the same PHY and device. Software polls the go bit, which doubles as the busy flag, until it reads 0 before it writes the next command. After a read frame the 16 bits returned by the PHY appear in the low half of the command register.

Internally, a phase state machine steps through five states. IDLE moves to PREAMBLE when a command is accepted. PREAMBLE moves to HEADER after the 32nd bit. HEADER moves to TURN after the 14 header bits. TURN moves to DATA after the two turnaround bits. DATA returns to IDLE after the 16th data bit. All transitions happen on MDC falling-edge strobes, and a clock generator produces those strobes.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register reads 0, MDC is low and `mdio_oe` is low.
- R2: The command word fields are: bit 31 go, bit 30 spare (stored as written), bits 29:25 register or device address, bits 24:20 PHY address, bits 19:18 opcode, bits 17:16 start code, bits 15:0 data or register address. A write with bit 31 = 0 is ignored and leaves the register and the line untouched.
- R3: The go bit reads 1 from the cycle after an accepted write until the frame ends, exactly 128*DIV_HALF system cycles after the accepting edge. It then reads 0.
- R4: Every frame is 64 bits sent MSB first, in this order: 32 ones, start code (01 = Clause 22, 00 = Clause 45), opcode (00 = Clause 45 address, 01 = write, 10 = Clause 22 read, 11 = Clause 45 read), PHY address, register/device address, 2 turnaround bits, 16 data bits.
- R5: In frames whose opcode bit 1 is 0 (write and address frames), the master drives the turnaround as 1 then 0, then drives data bits 15:0 of the command.
- R6: In frames whose opcode bit 1 is 1 (read frames), `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 bits sampled in the data phase, MSB first, replace bits 15:0 when the frame completes.
- R7: MDC has a period of 2*DIV_HALF system cycles. It starts low, `mdio_o` changes only when MDC falls (or at launch), and `mdio_i` is sampled when MDC rises.
- R8: A command written while the go bit is 1 is ignored. The register does not change during a frame, and the frame on the line is unaffected.
- R9: Whenever the go bit is 0, MDC is low and `mdio_oe` is low.
- R10: When a write or address frame completes, only the go bit clears. All other bits keep their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register contents (busy flag in bit 31) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the line |

## Verification
An accepted write at clock edge E0 makes the go bit read 1 right after E0. The go bit stays 1 through edge E0+128*DIV_HALF-1 and reads 0 after edge E0+128*DIV_HALF. At that same edge the read data and the idle line state become visible. The driver records E0 from a free-running edge counter and samples these results on the falling clock edge right after E0+128*DIV_HALF-1 and E0+128*DIV_HALF. The monitor collects the 64 line bits on MDC rising edges and compares them, together with the enable pattern, against the item the driver queued. The responder drives returned data after each MDC fall in the data phase, one half-period before the master samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_LAST   = 31;
    localparam int HDR_LAST   = 45;
    localparam int TA_LAST    = 47;
    localparam int DATA_W     = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    typedef struct packed {
        logic        go;
        logic        spare;
        logic [4:0]  regad;
        logic [4:0]  phy;
        logic [1:0]  op;
        logic [1:0]  st;
        logic [15:0] data;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == CW'(DIV_HALF - 1));
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  logic        fall_stb,
    output mdio_state_e state,
    output logic [5:0]  bit_idx,
    output logic        ph_drive,
    output logic        ph_resp,
    output logic        ph_data,
    output logic        done
);
    mdio_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            bit_idx <= '0;
        else if (launch)                       bit_idx <= '0;
        else if (fall_stb && state != ST_IDLE) bit_idx <= bit_idx + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (launch) nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_stb && bit_idx == 6'(PRE_LAST)) nxt = ST_HEADER;
            ST_HEADER:   if (fall_stb && bit_idx == 6'(HDR_LAST)) nxt = ST_TURN;
            ST_TURN:     if (fall_stb && bit_idx == 6'(TA_LAST))  nxt = ST_DATA;
            ST_DATA:     if (fall_stb && bit_idx == 6'(FRAME_BITS - 1)) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ph_drive = 1'b0;
        ph_resp  = 1'b0;
        ph_data  = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_PREAMBLE: ph_drive = 1'b1;
            ST_HEADER:   ph_drive = 1'b1;
            ST_TURN:     ph_resp  = 1'b1;
            ST_DATA: begin
                ph_resp = 1'b1;
                ph_data = 1'b1;
                done    = fall_stb && (bit_idx == 6'(FRAME_BITS - 1));
            end
            default:     ;
        endcase
    end
endmodule

// File: rtl/mdio_shreg.sv
module mdio_shreg #(
    parameter int W    = 64,
    parameter int CAPW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    load_val,
    input  logic            shift,
    input  logic            capture,
    input  logic            sin,
    output logic            sout,
    output logic [CAPW-1:0] cap
);
    logic [W-1:0] sreg;

    assign sout = sreg[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= load_val;
        else if (shift) sreg <= {sreg[W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap <= '0;
        else if (load)    cap <= '0;
        else if (capture) cap <= {cap[CAPW-2:0], sin};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t   cmd_q;
    mdio_cmd_t   wr;
    mdio_state_e state;
    logic [5:0]  bit_idx;
    logic        launch, done, rise_stb, fall_stb;
    logic        ph_drive, ph_resp, ph_data;
    logic        wr_is_read;
    logic [FRAME_BITS-1:0] frame_ld;
    logic [DATA_W-1:0]     cap;

    assign wr        = mdio_cmd_t'(cmd_wdata);
    assign launch    = cmd_we && wr.go && !cmd_q.go;
    assign cmd_rdata = cmd_q;
    assign mdio_oe   = ph_drive || (ph_resp && !cmd_q.op[1]);

    assign wr_is_read = wr.op[1];

    always_comb begin
        frame_ld = {32'hFFFF_FFFF, wr.st, wr.op, wr.phy, wr.regad,
                    wr_is_read ? 2'b11 : 2'b10,
                    wr_is_read ? 16'hFFFF : wr.data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (launch) begin
            cmd_q <= wr;
        end else if (done) begin
            cmd_q.go <= 1'b0;
            if (cmd_q.op[1]) cmd_q.data <= cap;
        end
    end

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cmd_q.go),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .fall_stb (fall_stb),
        .state    (state),
        .bit_idx  (bit_idx),
        .ph_drive (ph_drive),
        .ph_resp  (ph_resp),
        .ph_data  (ph_data),
        .done     (done)
    );

    mdio_shreg #(.W(FRAME_BITS), .CAPW(DATA_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (frame_ld),
        .shift    (fall_stb && state != ST_IDLE),
        .capture  (rise_stb && ph_data),
        .sin      (mdio_i),
        .sout     (mdio_o),
        .cap      (cap)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [5:0]  bit_idx
);
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[31] |-> (!mdio_oe && !mdc));

    assert_cmd_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[31] && $past(cmd_rdata[31])) |-> $stable(cmd_rdata));

    assert_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_rdata[31]) |-> (mdio_oe && mdio_o && !mdc && bit_idx == 6'd0));

    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[31] && cmd_rdata[19] && bit_idx >= 6'd46) |-> !mdio_oe);

    assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[31] && !cmd_rdata[19]) |-> mdio_oe);

    assert_change_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[31] && $past(cmd_rdata[31]) && !$fell(mdc)) |-> $stable(mdio_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .bit_idx   (bit_idx)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 2;
    localparam int FRAME_CYC  = 128 * DIV_HALF;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
    } wire_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] phy_val = '0;
    wire_item_t  expq[$];

    mdio_master #(.DIV_HALF(DIV_HALF)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: collect line bits on MDC rise, compare with queued item
    int rises = 0;
    logic [63:0] got_b = '0, got_oe = '0;
    realtime last_rise = 0;
    always @(posedge mdc) begin
        if (rises == 1)
            chk(($realtime - last_rise) == 2 * DIV_HALF * CLK_PERIOD, "R7 mdc period",
                64'($rtoi($realtime - last_rise)), 64'(2 * DIV_HALF * CLK_PERIOD));
        last_rise = $realtime;
        got_b[63 - rises]  = mdio_o;
        got_oe[63 - rises] = mdio_oe;
        rises++;
        if (rises == 64) begin
            rises = 0;
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected frame", got_b, 64'h0);
            end else begin
                wire_item_t e;
                e = expq.pop_front();
                chk((got_b & e.oe) == (e.bits & e.oe), "R4 R5 frame bits", got_b & e.oe, e.bits & e.oe);
                chk(got_oe == e.oe, "R6 enable pattern", got_oe, e.oe);
            end
        end
    end

    // PHY responder: drive read data after MDC falls in the data phase
    always @(negedge mdc) begin
        if (rises >= 48 && rises <= 63) mdio_i = phy_val[63 - rises];
        else                            mdio_i = 1'b1;
    end

    task automatic issue(input logic [31:0] cmd, input logic [15:0] pval, input bit intrude);
        wire_item_t e;
        int e0;
        logic [31:0] exp_reg;
        bit rd;
        rd = cmd[19];
        e.bits = {32'hFFFF_FFFF, cmd[17:16], cmd[19:18], cmd[24:20], cmd[29:25],
                  rd ? 2'b11 : 2'b10, cmd[15:0]};
        e.oe   = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
        expq.push_back(e);
        exp_reg = {1'b0, cmd[30:16], rd ? pval : cmd[15:0]};
        phy_val = pval;
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = cmd;
        @(posedge clk);
        e0 = cyc + 1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(cmd_rdata == {1'b1, cmd[30:0]}, "R2 R3 accepted", 64'(cmd_rdata), 64'({1'b1, cmd[30:0]}));
        if (intrude) begin
            repeat (40) @(negedge clk);
            cmd_we = 1'b1; cmd_wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            cmd_we = 1'b0;
            chk(cmd_rdata == {1'b1, cmd[30:0]}, "R8 ignored while busy", 64'(cmd_rdata), 64'({1'b1, cmd[30:0]}));
        end
        wait (cyc == e0 + FRAME_CYC - 1);
        @(negedge clk);
        chk(cmd_rdata[31] == 1'b1, "R3 busy until end", 64'(cmd_rdata[31]), 64'd1);
        wait (cyc == e0 + FRAME_CYC);
        @(negedge clk);
        chk(cmd_rdata[31] == 1'b0, "R3 busy cleared", 64'(cmd_rdata[31]), 64'd0);
        chk(cmd_rdata == exp_reg, rd ? "R6 read result" : "R10 write result", 64'(cmd_rdata), 64'(exp_reg));
        chk(!mdc && !mdio_oe, "R9 idle line", 64'({mdc, mdio_oe}), 64'd0);
        repeat (10) @(negedge clk);
        chk(!mdc && !mdio_oe, "R9 stays idle", 64'({mdc, mdio_oe}), 64'd0);
    endtask

    initial begin
        repeat (3000 * DIV_HALF) @(posedge clk);
        chk(1'b0, "watchdog", 64'(cyc), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit saw_mdc;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk(cmd_rdata == 32'h0, "R1 reset reg", 64'(cmd_rdata), 64'd0);
        chk(!mdc && !mdio_oe, "R1 reset line", 64'({mdc, mdio_oe}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_rdata == 32'h0, "R1 after release", 64'(cmd_rdata), 64'd0);

        // Clause 22 write: st=01 op=01
        issue({1'b1, 1'b0, 5'h04, 5'h01, 2'b01, 2'b01, 16'hA5C3}, 16'h0, 1'b0);
        // Clause 22 read: st=01 op=10
        issue({1'b1, 1'b1, 5'h02, 5'h1F, 2'b10, 2'b01, 16'h0000}, 16'h1234, 1'b0);
        // Clause 45 address frame: st=00 op=00, data carries register address
        issue({1'b1, 1'b0, 5'h07, 5'h03, 2'b00, 2'b00, 16'h003C}, 16'h0, 1'b0);
        // Clause 45 write: st=00 op=01
        issue({1'b1, 1'b0, 5'h07, 5'h03, 2'b01, 2'b00, 16'hBEEF}, 16'h0, 1'b0);
        // Clause 45 address then read, boundary data 8001
        issue({1'b1, 1'b0, 5'h1E, 5'h10, 2'b00, 2'b00, 16'hFFFF}, 16'h0, 1'b0);
        issue({1'b1, 1'b0, 5'h1E, 5'h10, 2'b11, 2'b00, 16'h0000}, 16'h8001, 1'b0);
        // write while busy is ignored (R8)
        issue({1'b1, 1'b0, 5'h11, 5'h0A, 2'b01, 2'b01, 16'h5A5A}, 16'h0, 1'b1);

        // R2: write with go=0 is ignored
        held = cmd_rdata;
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 32'h7FFF_FFFF;
        @(negedge clk);
        cmd_we = 1'b0;
        saw_mdc = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mdc || mdio_oe) saw_mdc = 1'b1;
        end
        chk(cmd_rdata == held, "R2 go=0 ignored reg", 64'(cmd_rdata), 64'(held));
        chk(!saw_mdc, "R2 go=0 no frame", 64'(saw_mdc), 64'd0);
        chk(expq.size() == 0, "R4 all frames seen", 64'(expq.size()), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule